// File: doc/BRIEF.md
# Dual-Width Timer With Compare Blocking

This block is a timer/counter that runs either as an 8-bit counter or as a single 16-bit counter. It advances only on clock cycles where a timer-tick strobe is high. Two compare registers, A and B, each raise a sticky match flag when the counter equals them. In 16-bit mode only compare A exists, and it compares all 16 bits. A third flag records overflow, which happens when the counter passes its absolute maximum. Each flag drives an interrupt request when its enable bit is set. A flag clears when its acknowledge input pulses, or when software writes a 1 to it.

Software reaches the block through a byte-wide register write port. The port uses a valid/ready handshake, but `bus_ready` is tied high, so a write is accepted in every cycle in which `bus_valid` is high and there is never back-pressure. Any write to a counter byte suppresses compare matches on the next timer tick, even if several idle cycles pass first. This lets software load the counter with a compare value without raising a spurious match. Three mode bits choose the counter width, clear-on-compare operation and input-capture operation. The capture datapath itself is not part of this block.

Top module: `dual_width_timer`

## Requirements
- R1: After reset, `count` is 0, `flags` and `irq` are 0, every register is 0, and `bus_ready` is 1.
- R2: The counter changes only on a cycle with `tick_en` high and no counter-byte write. On such a tick it steps by one toward its top, and it holds its value otherwise.
- R3: With mode register (address 0) bits `[2:0]` = 000, the counter is 8 bits wide. On the tick where it equals 0xFF it wraps to 0 and sets the overflow flag (`flags[2]`).
- R4: Mode bit 1 selects 16-bit width. In 16-bit mode the counter wraps from 0xFFFF to 0 and sets overflow. Mode bit 2 (capture) without bit 1 gives an 8-bit counter that tops at 0xFF. Mode bit 0 (clear-on-compare) is ignored whenever bit 1 or bit 2 is set.
- R5: With mode = 001, the counter clears to 0 on the tick where its low byte equals compare A's low byte. Overflow is raised only on a tick at 0xFF, so it never occurs when compare A is below 0xFF.
- R6: In 8-bit modes, a tick where the counter's low byte equals compare A's low byte (address 5) sets `flags[0]`. A tick where it equals compare B (address 7) sets `flags[1]`.
- R7: In 16-bit mode, a tick where the counter equals the full compare A (high byte at address 6) sets `flags[0]`, and `flags[1]` is never set.
- R8: A write to address 3 or address 4 blocks both compare flags on the first tick that follows, no matter how many tick-free cycles come between. A counter loaded with a compare value therefore loses that match.
- R9: A write to address 4 only stages a high byte. A write to address 3 loads the counter: in 16-bit mode with {staged byte, data}, in 8-bit modes with {0x00, data}.
- R10: A flag clears when its `irq_ack` bit is high or when a write to address 2 carries a 1 in its bit position (bit 0 = A, bit 1 = B, bit 2 = overflow). A set in the same cycle wins over the clear.
- R11: `irq[i]` is high exactly while `flags[i]` and enable bit i of address 1 are both set.
- R12: Compare register writes take effect on the next tick, with no double buffering.
- R13: When a counter-byte write and `tick_en` fall in the same cycle, the write wins: the tick neither advances the counter nor raises any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register write request |
| bus_ready | output | 1 | Write accepted (always 1) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data byte |
| tick_en | input | 1 | Timer clock enable strobe |
| irq_ack | input | 3 | Per-flag interrupt acknowledge (0 = A, 1 = B, 2 = overflow) |
| count | output | 16 | Current counter value |
| flags | output | 3 | Match A, match B, overflow flags |
| irq | output | 3 | Interrupt requests |

## Verification
Two events can land on the same flag in one cycle: a compare match or an overflow that sets it, and an acknowledge or a write-1-to-clear that clears it. A directed case steers the counter onto compare A and pulses both clears on exactly that tick. The flag must then read 1, and a later lone acknowledge must clear it. A long random phase mixes acknowledges, flag writes, counter loads and ticks. After every cycle the flags are compared with a bench model in which a set takes priority over a clear.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 3;
  localparam int FL_A   = 0;
  localparam int FL_B   = 1;
  localparam int FL_OV  = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_MODE   = 3'd0,
    RA_IEN    = 3'd1,
    RA_FLAGS  = 3'd2,
    RA_CNT_LO = 3'd3,
    RA_CNT_HI = 3'd4,
    RA_CA_LO  = 3'd5,
    RA_CA_HI  = 3'd6,
    RA_CB     = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic cap;
    logic wide;
    logic ctc;
  } mode_t;
endpackage

// File: rtl/dwt_regs.sv
module dwt_regs
  import dwt_pkg::*;
#(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BW-1:0]       wdata,
  output mode_t               mode,
  output logic [NFLAG-1:0]    ien,
  output logic [CW-1:0]       cmpa,
  output logic [BW-1:0]       cmpb,
  output logic                cnt_wr,
  output logic                cnt_load,
  output logic [CW-1:0]       load_val,
  output logic [NFLAG-1:0]    w1c
);
  logic [BW-1:0] stage_hi;
  reg_addr_e     ra;

  assign ra       = reg_addr_e'(addr);
  assign cnt_load = wr && (ra == RA_CNT_LO);
  assign cnt_wr   = cnt_load || (wr && (ra == RA_CNT_HI));
  assign load_val = {stage_hi, wdata};
  assign w1c      = (wr && (ra == RA_FLAGS)) ? wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= '0;
      ien      <= '0;
      cmpa     <= '0;
      cmpb     <= '0;
      stage_hi <= '0;
    end else if (wr) begin
      case (ra)
        RA_MODE:   mode          <= mode_t'(wdata[2:0]);
        RA_IEN:    ien           <= wdata[NFLAG-1:0];
        RA_CNT_HI: stage_hi      <= wdata;
        RA_CA_LO:  cmpa[BW-1:0]  <= wdata;
        RA_CA_HI:  cmpa[CW-1:BW] <= wdata;
        RA_CB:     cmpb          <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dwt_core.sv
module dwt_core
  import dwt_pkg::*;
#(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  mode_t            mode,
  input  logic [CW-1:0]    cmpa,
  input  logic [BW-1:0]    cmpb,
  input  logic             cnt_wr,
  input  logic             cnt_load,
  input  logic [CW-1:0]    load_val,
  output logic [CW-1:0]    count,
  output logic [NFLAG-1:0] set_ev,
  output logic             blk
);
  localparam logic [CW-1:0] MAX8  = {{BW{1'b0}}, {BW{1'b1}}};
  localparam logic [CW-1:0] MAX16 = '1;

  logic          wide, ctc_eff, step;
  logic [CW-1:0] cur, top, maxv, nxt;
  logic [BW-1:0] low_inc;
  logic          hit_a, hit_b;

  assign wide    = mode.wide;
  assign ctc_eff = mode.ctc && !mode.wide && !mode.cap;
  assign step    = tick && !cnt_wr;
  assign cur     = wide ? count : {{BW{1'b0}}, count[BW-1:0]};
  assign maxv    = wide ? MAX16 : MAX8;
  assign top     = wide ? MAX16 : (ctc_eff ? {{BW{1'b0}}, cmpa[BW-1:0]} : MAX8);
  assign low_inc = cur[BW-1:0] + 1'b1;

  always_comb begin
    if (cur == top)
      nxt = '0;
    else if (wide)
      nxt = cur + 1'b1;
    else
      nxt = {{BW{1'b0}}, low_inc};
  end

  assign hit_a = wide ? (cur == cmpa) : (cur[BW-1:0] == cmpa[BW-1:0]);
  assign hit_b = !wide && (cur[BW-1:0] == cmpb);

  assign set_ev[FL_A]  = step && !blk && hit_a;
  assign set_ev[FL_B]  = step && !blk && hit_b;
  assign set_ev[FL_OV] = step && (cur == maxv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      blk   <= 1'b0;
    end else begin
      if (cnt_load)
        count <= wide ? load_val : {{BW{1'b0}}, load_val[BW-1:0]};
      else if (step)
        count <= nxt;

      if (cnt_wr)
        blk <= 1'b1;
      else if (tick)
        blk <= 1'b0;
    end
  end
endmodule

// File: rtl/dwt_flag.sv
module dwt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic flag,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else
      flag <= (flag && !clr) || set;
  end

  assign req = flag && en;
endmodule

// File: rtl/dual_width_timer.sv
module dual_width_timer
  import dwt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  output logic                bus_ready,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  input  logic                tick_en,
  input  logic [NFLAG-1:0]    irq_ack,
  output logic [CNT_W-1:0]    count,
  output logic [NFLAG-1:0]    flags,
  output logic [NFLAG-1:0]    irq
);
  mode_t              mode_q;
  logic [NFLAG-1:0]   ien, w1c, set_ev;
  logic [CNT_W-1:0]   cmpa, load_val;
  logic [BYTE_W-1:0]  cmpb;
  logic               cnt_wr, cnt_load, blk, wr;

  assign bus_ready = 1'b1;
  assign wr        = bus_valid && bus_ready;

  dwt_regs #(.BW(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(bus_addr), .wdata(bus_wdata),
    .mode(mode_q), .ien(ien), .cmpa(cmpa), .cmpb(cmpb),
    .cnt_wr(cnt_wr), .cnt_load(cnt_load), .load_val(load_val), .w1c(w1c)
  );

  dwt_core #(.BW(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .mode(mode_q),
    .cmpa(cmpa), .cmpb(cmpb), .cnt_wr(cnt_wr), .cnt_load(cnt_load),
    .load_val(load_val), .count(count), .set_ev(set_ev), .blk(blk)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    dwt_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(set_ev[i]),
      .clr(irq_ack[i] || w1c[i]), .en(ien[i]),
      .flag(flags[i]), .req(irq[i])
    );
  end
endmodule

// File: rtl/dwt_chk.sv
module dwt_chk #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic [CW-1:0] count,
  input logic [2:0]    flags,
  input logic [2:0]    irq,
  input logic          cnt_wr,
  input logic          blk,
  input logic          wide
);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(count));

  // R4
  wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr && wide && (count == '1)) |=> ((count == '0) && flags[2]));

  // R7
  no_b_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && tick_en && !cnt_wr) |=> !$rose(flags[1]));

  // R8
  block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && tick_en && !cnt_wr) |=> (!$rose(flags[0]) && !$rose(flags[1])));

  // R13
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && tick_en) |=> (!$rose(flags[0]) && !$rose(flags[1]) && !$rose(flags[2])));

  // R11
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~flags) == 3'b000));
endmodule

bind dual_width_timer dwt_chk #(.BW(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count),
  .flags(flags), .irq(irq), .cnt_wr(cnt_wr), .blk(blk), .wide(mode_q.wide)
);

// File: tb/sim_dual_width_timer.sv
`timescale 1ns/1ps
module sim_dual_width_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        tick_en = 1'b0;
  logic [2:0]  irq_ack = '0;
  logic [15:0] count;
  logic [2:0]  flags, irq;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [2:0]  m_mode = '0, m_ien = '0, m_fl = '0;
  logic [15:0] m_ca = '0, m_cnt = '0;
  logic [7:0]  m_cb = '0, m_stg = '0;
  logic        m_blk = 1'b0;

  always #10 clk = ~clk;

  dual_width_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tick_en(tick_en),
    .irq_ack(irq_ack), .count(count), .flags(flags), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model of one clock edge, built from the requirements
  task automatic model_step(input logic v, input logic [2:0] a, input logic [7:0] d,
                            input logic t, input logic [2:0] k);
    logic wide, ctc, cw, st, hit_a, hit_b;
    logic [15:0] cur, top, mx, nx;
    logic [2:0] setv, clr;
    wide = m_mode[1];
    ctc  = m_mode[0] && !m_mode[1] && !m_mode[2];
    cw   = v && (a == 3'd3 || a == 3'd4);
    st   = t && !cw;
    cur  = wide ? m_cnt : {8'h00, m_cnt[7:0]};
    mx   = wide ? 16'hFFFF : 16'h00FF;
    top  = wide ? 16'hFFFF : (ctc ? {8'h00, m_ca[7:0]} : 16'h00FF);
    if (cur == top) nx = 16'h0;
    else if (wide) nx = cur + 16'd1;
    else nx = {8'h00, cur[7:0] + 8'd1};
    hit_a = wide ? (cur == m_ca) : (cur[7:0] == m_ca[7:0]);
    hit_b = !wide && (cur[7:0] == m_cb);
    setv  = {st && (cur == mx), st && !m_blk && hit_b, st && !m_blk && hit_a};
    clr   = k | ((v && a == 3'd2) ? d[2:0] : 3'b000);
    m_fl  = (m_fl & ~clr) | setv;
    if (v && a == 3'd3) m_cnt = wide ? {m_stg, d} : {8'h00, d};
    else if (st) m_cnt = nx;
    if (cw) m_blk = 1'b1;
    else if (t) m_blk = 1'b0;
    if (v) begin
      case (a)
        3'd0: m_mode = d[2:0];
        3'd1: m_ien = d[2:0];
        3'd4: m_stg = d;
        3'd5: m_ca[7:0] = d;
        3'd6: m_ca[15:8] = d;
        3'd7: m_cb = d;
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic v, input logic [2:0] a, input logic [7:0] d,
                      input logic t, input logic [2:0] k);
    bus_valid = v; bus_addr = a; bus_wdata = d; tick_en = t; irq_ack = k;
    @(posedge clk);
    model_step(v, a, d, t, k);
    @(negedge clk);
    bus_valid = 1'b0; tick_en = 1'b0; irq_ack = '0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 3'b000);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 8'h00, 1'b1, 3'b000);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 8'h00, 1'b0, 3'b000);
  endtask

  task automatic model_chk(input string tag);
    check({tag, " count"}, count, m_cnt);
    check({tag, " flags"}, {13'd0, flags}, {13'd0, m_fl});
    check({tag, " irq"}, {13'd0, irq}, {13'd0, m_fl & m_ien});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(64'd200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", count, 16'h0);
    check("R1 flags", {13'd0, flags}, 16'h0);
    check("R1 irq", {13'd0, irq}, 16'h0);
    check("R1 ready", {15'd0, bus_ready}, 16'h1);

    // R2 counting and holding
    ticks(3);
    check("R2 advance", count, 16'h3);
    idle(2);
    check("R2 hold", count, 16'h3);
    model_chk("R2");

    // R3 8-bit wrap with overflow
    wreg(3'd2, 8'h07);
    wreg(3'd3, 8'hFE);
    ticks(2);
    check("R3 wrap", count, 16'h0);
    check("R3 ovf", {15'd0, flags[2]}, 16'h1);

    // R5 clear on compare A
    wreg(3'd0, 8'h01);
    wreg(3'd5, 8'h05);
    wreg(3'd6, 8'h00);
    wreg(3'd2, 8'h07);
    wreg(3'd3, 8'h00);
    ticks(6);
    check("R5 clear", count, 16'h0);
    check("R5 no ovf", {13'd0, flags}, 16'h1);

    // R12 compare change takes effect at once
    wreg(3'd5, 8'h02);
    ticks(3);
    check("R12 new top", count, 16'h0);
    model_chk("R12");

    // R4 and R9 16-bit staging and wrap
    wreg(3'd0, 8'h02);
    wreg(3'd2, 8'h07);
    wreg(3'd4, 8'hFF);
    check("R9 stage only", count, 16'h0);
    wreg(3'd3, 8'hFE);
    check("R9 atomic load", count, 16'hFFFE);
    ticks(2);
    check("R4 wrap16", count, 16'h0);
    check("R4 ovf16", {15'd0, flags[2]}, 16'h1);

    // R4 capture mode ignores clear-on-compare (compare A low = 2)
    wreg(3'd0, 8'h05);
    wreg(3'd3, 8'h01);
    ticks(2);
    check("R4 cap ctc ignored", count, 16'h3);
    model_chk("R4");

    // R8 blocked match after counter write, across idle cycles
    wreg(3'd0, 8'h00);
    wreg(3'd5, 8'h20);
    wreg(3'd2, 8'h07);
    wreg(3'd3, 8'h20);
    idle(3);
    ticks(1);
    check("R8 count", count, 16'h21);
    check("R8 blocked", {15'd0, flags[0]}, 16'h0);
    // R6 normal match
    wreg(3'd3, 8'h1F);
    ticks(2);
    check("R6 match A", {13'd0, flags}, 16'h1);
    model_chk("R6");

    // R7 16-bit: only A, full width
    wreg(3'd0, 8'h02);
    wreg(3'd5, 8'h00);
    wreg(3'd6, 8'h01);
    wreg(3'd7, 8'h01);
    wreg(3'd2, 8'h07);
    wreg(3'd4, 8'h00);
    wreg(3'd3, 8'h00);
    ticks(3);
    check("R7 no B", {13'd0, flags}, 16'h0);
    wreg(3'd3, 8'hFF);
    ticks(2);
    check("R7 count", count, 16'h0101);
    check("R7 A only", {13'd0, flags}, 16'h1);

    // R10 set wins over simultaneous ack and write-1-to-clear
    wreg(3'd0, 8'h00);
    wreg(3'd5, 8'h40);
    wreg(3'd2, 8'h07);
    wreg(3'd3, 8'h3F);
    ticks(1);
    step(1'b1, 3'd2, 8'h01, 1'b1, 3'b001);
    check("R10 set wins", {15'd0, flags[0]}, 16'h1);
    // R11 request follows enable
    wreg(3'd1, 8'h01);
    check("R11 irq on", {13'd0, irq}, 16'h1);
    step(1'b0, 3'd0, 8'h00, 1'b0, 3'b001);
    check("R10 ack clears", {15'd0, flags[0]}, 16'h0);
    check("R11 irq off", {13'd0, irq}, 16'h0);

    // R13 write beats simultaneous tick
    step(1'b1, 3'd3, 8'h10, 1'b1, 3'b000);
    check("R13 write wins", count, 16'h10);
    model_chk("R13");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic v, t;
      logic [2:0] a, k;
      logic [7:0] d;
      v = ($urandom % 4) == 0;
      a = 3'($urandom % 8);
      d = 8'($urandom);
      if (a == 3'd0 && ($urandom % 4) != 0) v = 1'b0;
      if (a == 3'd3 || a == 3'd5 || a == 3'd7) d = d & 8'h1F;
      t = ($urandom % 10) < 7;
      k = (($urandom % 10) == 0) ? 3'($urandom) : 3'b000;
      step(v, a, d, t, k);
      check("R2 rand count", count, m_cnt);
      check("R6 rand flags", {13'd0, flags}, {13'd0, m_fl});
      check("R11 rand irq", {13'd0, irq}, {13'd0, m_fl & m_ien});
    end
    finish_run();
  end
endmodule